// File: doc/BRIEF.md
# First-Data Timeout Monitor

This block watches one bus transaction at a time and raises a disconnect request when the first data transfer has not finished within a programmable number of bus clocks. The controller that owns the bus signals when a transaction starts, when its first data transfer completes and when the transaction ends. The monitor turns these strobes and a 3-bit timeout code into a single-cycle request to the target interface, which then performs the actual disconnect.

The timeout code selects a limit in steps of 32 clocks. Code 0 turns the monitor off for the transaction that begins under it. The code is captured when a transaction is accepted, so a later change only affects the next transaction. Once the first data transfer is seen, the monitor stops counting and stays silent until the transaction ends.

The control is a four-state machine. ST_IDLE waits for a start strobe. On an accepted start it moves to ST_COUNT if the code is nonzero, or to ST_QUIET if the code is zero. ST_COUNT advances the cycle counter. It moves to ST_QUIET when first data is seen, to ST_FIRED when the limit is reached, and back to ST_IDLE on a transaction end. ST_QUIET and ST_FIRED both hold until a transaction end returns the machine to ST_IDLE. A transaction end takes priority over every other strobe in every state.

Top module: `first_data_tmo`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `disc_req` is 0 and the monitor is idle.
- R2: With a captured code N in the range 1 to 7, the limit is L = N*32 clocks. Take the edge that samples `txn_start` as edge 0. If no first data and no end arrive, `disc_req` is high in the cycle that follows edge L, and in no other cycle.
- R3: A transaction accepted with code 0 never produces `disc_req`, however long it lasts.
- R4: If `first_data` is sampled high at any edge from 1 to L, there is no `disc_req` for that transaction. This holds even when first data arrives on edge L itself. First data sampled after edge L is too late to stop the request.
- R5: `disc_req` is high for one cycle only and is raised at most once per transaction.
- R6: If `txn_end` is sampled at or before edge L, it cancels the pending request. It also returns the monitor to idle, so the next `txn_start` begins a fresh count from zero.
- R7: The code is sampled only on the edge that accepts `txn_start`. A change of `tmo_code` during a transaction does not alter that transaction's limit.
- R8: A `txn_start` strobe that arrives while a transaction is in progress is ignored. It neither restarts the count nor delays the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Strobe: a master has begun a transaction |
| first_data | input | 1 | Strobe: the first data transfer has completed |
| txn_end | input | 1 | Strobe: the transaction has finished |
| tmo_code | input | 3 | Timeout code; 0 = off, N = N*32 clocks |
| disc_req | output | 1 | One-cycle disconnect request |

## Verification
A wrong state or counter value shows at the ports as a request that is early, late, repeated or missing. The request moment is fixed exactly at L cycles after the start edge, so any miscount of even one cycle appears in the first transaction with a nonzero code. The bench sweeps every code against first-data arrival and end timing placed just before, at and just after the limit. A stray restart or a failure to capture the code changes the request cycle within that transaction. A state that is not cleared by an end shows up in the following transaction.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_QUIET,
        ST_FIRED
    } tmo_state_t;

endpackage

// File: rtl/tmo_limit_dec.sv
module tmo_limit_dec #(
    parameter int CODE_W = 3,
    parameter int STEP   = 32,
    parameter int LIM_W  = 8
) (
    input  logic [CODE_W-1:0] code,
    output logic [LIM_W-1:0]  limit,
    output logic              off
);
    localparam logic [LIM_W-1:0] STEP_L = LIM_W'(STEP);

    always_comb begin
        limit = LIM_W'(code) * STEP_L;
        off   = (code == '0);
    end

    always_comb begin
        a_zero_off_r3: assert ((limit == '0) == off);
    end
endmodule

// File: rtl/tmo_cycle_ctr.sv
module tmo_cycle_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + W'(1);
        end
    end

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/first_data_tmo.sv
module first_data_tmo #(
    parameter int CODE_W = 3,
    parameter int STEP   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              first_data,
    input  logic              txn_end,
    input  logic [CODE_W-1:0] tmo_code,
    output logic              disc_req
);
    import tmo_pkg::*;

    localparam int MAX_LIM = ((1 << CODE_W) - 1) * STEP;
    localparam int LIM_W   = $clog2(MAX_LIM + 1);

    tmo_state_t       state, state_nx;
    logic [LIM_W-1:0] lim_dec, lim_q, cnt;
    logic             code_off, accept, hit;

    tmo_limit_dec #(.CODE_W(CODE_W), .STEP(STEP), .LIM_W(LIM_W)) u_dec (
        .code  (tmo_code),
        .limit (lim_dec),
        .off   (code_off)
    );

    tmo_cycle_ctr #(.W(LIM_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept || txn_end),
        .en    (state == ST_COUNT),
        .cnt   (cnt)
    );

    assign accept = (state == ST_IDLE) && txn_start && !txn_end;
    assign hit    = (state == ST_COUNT) && !first_data && !txn_end
                    && (cnt == lim_q - LIM_W'(1));

    // captured limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
        end else if (accept) begin
            lim_q <= lim_dec;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = code_off ? ST_QUIET : ST_COUNT;
            ST_COUNT: begin
                if (txn_end)         state_nx = ST_IDLE;
                else if (first_data) state_nx = ST_QUIET;
                else if (hit)        state_nx = ST_FIRED;
            end
            ST_QUIET: if (txn_end) state_nx = ST_IDLE;
            ST_FIRED: if (txn_end) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) disc_req <= 1'b0;
        else        disc_req <= hit;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!disc_req && state == ST_IDLE));

    p_fire_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        disc_req |-> (cnt == lim_q && state == ST_FIRED));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> (cnt < lim_q));

    p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disc_req |-> (lim_q != '0));

    p_quiet_after_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUIET) |=> !disc_req);

    p_one_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        disc_req |=> !disc_req);

    p_end_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end |=> (state == ST_IDLE && !disc_req));

    p_code_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !accept) |=> $stable(lim_q));
endmodule

// File: tb/first_data_tmo_test.sv
`timescale 1ns/1ps
module first_data_tmo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0;
    logic       first_data = 1'b0;
    logic       txn_end = 1'b0;
    logic [2:0] tmo_code = 3'd0;
    logic       disc_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    first_data_tmo uut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start),
        .first_data(first_data), .txn_end(txn_end),
        .tmo_code(tmo_code), .disc_req(disc_req)
    );

    task automatic check(input string req, input logic act, input logic exp, input int k);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d: disc_req=%0b expected=%0b", req, k, act, exp);
        end
    endtask

    // one transaction; data_at/restart_at of 0 means never
    task automatic run_txn(input int code, input int data_at, input int end_at,
                           input int mid_code, input int restart_at, input string req);
        int lim;
        int fire_k;
        int pulses;
        lim = code * 32;
        fire_k = (code != 0 && (data_at == 0 || data_at > lim) && end_at > lim) ? lim : -1;
        pulses = 0;
        @(negedge clk);
        txn_start = 1'b1;
        tmo_code = 3'(code);
        @(posedge clk); #1;
        check(req, disc_req, 1'b0, 0);
        for (int k = 1; k <= end_at; k++) begin
            @(negedge clk);
            txn_start  = (k == restart_at);
            first_data = (k == data_at);
            txn_end    = (k == end_at);
            tmo_code   = (k == 1) ? 3'(mid_code) : tmo_code;
            @(posedge clk); #1;
            if (disc_req === 1'b1) pulses++;
            check(req, disc_req, (k == fire_k), k);
        end
        @(negedge clk);
        txn_start = 1'b0; first_data = 1'b0; txn_end = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            check("R6", disc_req, 1'b0, end_at + 1 + k);
        end
        // R5: at most one pulse per transaction
        checks++;
        if (pulses != ((fire_k >= 0) ? 1 : 0)) begin
            failures++;
            $display("FAIL R5 pulses=%0d expected=%0d", pulses, (fire_k >= 0) ? 1 : 0);
        end
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            check("R1", disc_req, 1'b0, k);
        end
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", disc_req, 1'b0, 0);

        for (int c = 0; c < 8; c++) begin
            int lim;
            lim = c * 32;
            if (c == 0) begin
                run_txn(0, 0, 300, 0, 0, "R3");
                run_txn(0, 5, 40, 7, 0, "R3");
            end else begin
                run_txn(c, 0, lim + 4, c, 0, "R2");
                run_txn(c, 1, lim + 4, c, 0, "R4");
                run_txn(c, lim, lim + 4, c, 0, "R4");
                run_txn(c, lim + 1, lim + 4, c, 0, "R4");
                run_txn(c, 0, lim, c, 0, "R6");
                run_txn(c, 0, lim - 1, c, 0, "R6");
                run_txn(c, 0, lim + 4, (c % 7) + 1, 0, "R7");
                run_txn(c, 0, lim + 4, 0, 0, "R7");
                run_txn(c, 0, lim + 4, c, lim / 2, "R8");
            end
        end
        run_txn(0, 0, 100, 1, 20, "R8");
        run_txn(1, 0, 10, 1, 0, "R6");
        run_txn(1, 0, 40, 1, 0, "R6");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule